// File: doc/BRIEF.md
# Packed Saturating Subtract Unit

This unit subtracts one packed integer vector from another, lane by lane, and clamps each lane result to the range of its type. A single 64-bit datapath is split at run time into lanes of 8, 16, 32 or 64 bits. Each request also selects signed or unsigned lanes. All lanes of one operation share the same width and type. The register file is outside the block: the requester supplies the source words together with the register indices, and the unit returns each result word tagged with the index it belongs in.

A request carries a quad flag. With the flag clear, the unit processes one 64-bit word. With the flag set, it processes a register pair as two result beats over the same datapath: the low beat for index `n` and the high beat for index `n+1`. A quad request in which any of the three indices is odd is refused. It returns one result marked undefined, with no data. Every beat reports whether any of its lanes clamped. A sticky cumulative flag collects those reports until software clears it.

Requests enter on a valid/ready channel and results leave on a valid/ready channel. `req_ready` is high only while no result is pending, so a new request is not taken while an operation (including both beats of a quad) is still being delivered. A result word holds steady until `res_ready` accepts it. The second beat of a quad follows in the cycle after the first beat is accepted.

Top module: `psub_sat_unit`

## Requirements
- R1: After reset `res_valid` is 0, `req_ready` is 1 and `qc_flag` is 0.
- R2: `req_size` codes 0, 1, 2, 3 select lane widths 8, 16, 32, 64. Lane `i` of width `w` occupies bits `[i*w +: w]` of every word, with 64/w lanes per word.
- R3: With `req_uns`=1 each lane yields a−b when a ≥ b, and 0 with saturation when b > a.
- R4: With `req_uns`=0 each lane yields the two's-complement difference a−b. A result below the lane minimum becomes the minimum, one above the maximum becomes the maximum, and both count as saturation.
- R5: `res_sat` is 1 exactly when at least one lane of that result word was clamped.
- R6: `qc_flag` becomes 1 in the cycle a clamped result word is presented. It stays 1 through later non-saturating operations.
- R7: `qc_clear`=1 sets `qc_flag` to 0 at the next edge, even when a clamped word is loaded at that same edge.
- R8: With `req_quad`=0 one result is produced from the low operand words, with `res_dst`=`req_dst` and `res_last`=1.
- R9: With `req_quad`=1 and all indices even, two results follow. The first comes from the low operand words with `res_dst`=`req_dst` and `res_last`=0. The second comes from the high words with `res_dst`=`req_dst`+1 and `res_last`=1.
- R10: With `req_quad`=1 and bit 0 of any of `req_dst`, `req_src1`, `req_src2` set, one result appears with `res_undef`=1, `res_data`=0, `res_sat`=0 and `res_last`=1, and `qc_flag` is left unchanged.
- R11: A request accepted at an edge gives `res_valid`=1 after that edge. While `res_valid`=1 and `res_ready`=0, every result output stays unchanged.
- R12: `req_ready` is 0 while any result word is pending. A request offered then is not taken and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can take a request |
| req_size | input | 2 | Lane width code |
| req_uns | input | 1 | 1 = unsigned lanes, 0 = signed lanes |
| req_quad | input | 1 | 1 = register-pair operation |
| req_dst | input | 5 | Destination register index |
| req_src1 | input | 5 | Minuend register index |
| req_src2 | input | 5 | Subtrahend register index |
| req_opa_lo | input | 64 | Minuend word at index src1 |
| req_opb_lo | input | 64 | Subtrahend word at index src2 |
| req_opa_hi | input | 64 | Minuend word at index src1+1 (quad only) |
| req_opb_hi | input | 64 | Subtrahend word at index src2+1 (quad only) |
| res_valid | output | 1 | Result word presented |
| res_ready | input | 1 | Consumer accepts the result word |
| res_data | output | 64 | Packed clamped differences |
| res_dst | output | 5 | Register index of this result word |
| res_sat | output | 1 | Some lane of this word clamped |
| res_last | output | 1 | Final word of the operation |
| res_undef | output | 1 | Request refused for an odd quad index |
| qc_clear | input | 1 | Synchronous clear of the cumulative flag |
| qc_flag | output | 1 | Sticky cumulative saturation flag |

## Verification
A software clear of the cumulative flag can land on the same edge at which a clamping result word is loaded. The bench provokes this by raising `qc_clear` in the cycle a request is accepted whose unsigned lanes borrow. It expects `res_sat`=1 together with `qc_flag`=0 afterwards. The acceptance of a quad's first beat and the loading of its second also share an edge. That edge is exercised both with an immediate accept and with the consumer stalling for several cycles, while a competing request is held on the input, and each beat's word, index and flags are compared with a lane-by-lane arithmetic model.

// File: rtl/psub_pkg.sv
package psub_pkg;

  typedef struct packed {
    logic last;
    logic undef;
    logic sat;
  } beat_flags_t;

  function automatic int lane_width(input int min_lane, input int size_code);
    return min_lane << size_code;
  endfunction

endpackage

// File: rtl/psub_lane.sv
module psub_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         uns,
  output logic [W-1:0] y,
  output logic         sat
);
  logic [W:0] diff;
  logic       borrow;
  logic       ovf;

  assign diff   = {1'b0, a} - {1'b0, b};
  assign borrow = diff[W];
  assign ovf    = (a[W-1] ^ b[W-1]) & (diff[W-1] ^ a[W-1]);

  always_comb begin
    if (uns) begin
      sat = borrow;
      y   = borrow ? '0 : diff[W-1:0];
    end else begin
      sat = ovf;
      if (ovf) y = a[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
      else     y = diff[W-1:0];
    end
  end
endmodule

// File: rtl/psub_word.sv
module psub_word #(
  parameter int WORD_W    = 64,
  parameter int MIN_LANE  = 8,
  parameter int NUM_SIZES = 4,
  localparam int SZ_W     = $clog2(NUM_SIZES)
) (
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  input  logic [SZ_W-1:0]   size,
  input  logic              uns,
  output logic [WORD_W-1:0] y,
  output logic              sat
);
  logic [WORD_W-1:0] y_by [NUM_SIZES];
  logic              sat_by [NUM_SIZES];

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int LW = psub_pkg::lane_width(MIN_LANE, s);
    localparam int NL = WORD_W / LW;
    logic [WORD_W-1:0] ys;
    logic [NL-1:0]     ss;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      psub_lane #(.W(LW)) u_lane (
        .a   (a[l*LW +: LW]),
        .b   (b[l*LW +: LW]),
        .uns (uns),
        .y   (ys[l*LW +: LW]),
        .sat (ss[l])
      );
    end
    assign y_by[s]   = ys;
    assign sat_by[s] = |ss;
  end

  assign y   = y_by[size];
  assign sat = sat_by[size];
endmodule

// File: rtl/psub_seq.sv
module psub_seq #(
  parameter int WORD_W = 64,
  parameter int IDX_W  = 5,
  parameter int SZ_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SZ_W-1:0]   req_size,
  input  logic              req_uns,
  input  logic              req_quad,
  input  logic [IDX_W-1:0]  req_dst,
  input  logic [IDX_W-1:0]  req_src1,
  input  logic [IDX_W-1:0]  req_src2,
  input  logic [WORD_W-1:0] req_opa_lo,
  input  logic [WORD_W-1:0] req_opb_lo,
  input  logic [WORD_W-1:0] req_opa_hi,
  input  logic [WORD_W-1:0] req_opb_hi,
  input  logic              res_ready,
  input  logic              qc_clear,
  output logic [WORD_W-1:0] calc_a,
  output logic [WORD_W-1:0] calc_b,
  output logic [SZ_W-1:0]   calc_size,
  output logic              calc_uns,
  input  logic [WORD_W-1:0] calc_y,
  input  logic              calc_sat,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_data,
  output logic [IDX_W-1:0]  res_dst,
  output logic              res_sat,
  output logic              res_last,
  output logic              res_undef,
  output logic              qc_flag
);
  import psub_pkg::*;

  logic              valid_q;
  logic              more_q;
  logic [WORD_W-1:0] hold_a_q;
  logic [WORD_W-1:0] hold_b_q;
  logic [SZ_W-1:0]   hold_size_q;
  logic              hold_uns_q;
  logic [WORD_W-1:0] data_q;
  logic [IDX_W-1:0]  dst_q;
  beat_flags_t       flags_q;
  logic              qc_q;

  logic fire, odd_idx, refuse, advance, drain, sat_load;

  assign req_ready = !valid_q;
  assign fire      = req_valid && req_ready;
  assign odd_idx   = req_dst[0] | req_src1[0] | req_src2[0];
  assign refuse    = req_quad && odd_idx;
  assign drain     = valid_q && res_ready;
  assign advance   = drain && more_q;
  assign sat_load  = calc_sat && (advance || (fire && !refuse));

  always_comb begin
    if (advance) begin
      calc_a    = hold_a_q;
      calc_b    = hold_b_q;
      calc_size = hold_size_q;
      calc_uns  = hold_uns_q;
    end else begin
      calc_a    = req_opa_lo;
      calc_b    = req_opb_lo;
      calc_size = req_size;
      calc_uns  = req_uns;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q     <= 1'b0;
      more_q      <= 1'b0;
      hold_a_q    <= '0;
      hold_b_q    <= '0;
      hold_size_q <= '0;
      hold_uns_q  <= 1'b0;
      data_q      <= '0;
      dst_q       <= '0;
      flags_q     <= '0;
    end else if (fire) begin
      valid_q       <= 1'b1;
      more_q        <= req_quad && !refuse;
      hold_a_q      <= req_opa_hi;
      hold_b_q      <= req_opb_hi;
      hold_size_q   <= req_size;
      hold_uns_q    <= req_uns;
      data_q        <= refuse ? '0 : calc_y;
      dst_q         <= req_dst;
      flags_q.sat   <= refuse ? 1'b0 : calc_sat;
      flags_q.undef <= refuse;
      flags_q.last  <= !(req_quad && !refuse);
    end else if (advance) begin
      more_q        <= 1'b0;
      data_q        <= calc_y;
      dst_q         <= dst_q + 1'b1;
      flags_q.sat   <= calc_sat;
      flags_q.undef <= 1'b0;
      flags_q.last  <= 1'b1;
    end else if (drain) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        qc_q <= 1'b0;
    else if (qc_clear) qc_q <= 1'b0;
    else if (sat_load) qc_q <= 1'b1;
  end

  assign res_valid = valid_q;
  assign res_data  = data_q;
  assign res_dst   = dst_q;
  assign res_sat   = flags_q.sat;
  assign res_last  = flags_q.last;
  assign res_undef = flags_q.undef;
  assign qc_flag   = qc_q;
endmodule

// File: rtl/psub_sat_unit.sv
module psub_sat_unit #(
  parameter int WORD_W    = 64,
  parameter int MIN_LANE  = 8,
  parameter int NUM_SIZES = 4,
  parameter int IDX_W     = 5,
  localparam int SZ_W     = $clog2(NUM_SIZES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SZ_W-1:0]   req_size,
  input  logic              req_uns,
  input  logic              req_quad,
  input  logic [IDX_W-1:0]  req_dst,
  input  logic [IDX_W-1:0]  req_src1,
  input  logic [IDX_W-1:0]  req_src2,
  input  logic [WORD_W-1:0] req_opa_lo,
  input  logic [WORD_W-1:0] req_opb_lo,
  input  logic [WORD_W-1:0] req_opa_hi,
  input  logic [WORD_W-1:0] req_opb_hi,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [WORD_W-1:0] res_data,
  output logic [IDX_W-1:0]  res_dst,
  output logic              res_sat,
  output logic              res_last,
  output logic              res_undef,
  input  logic              qc_clear,
  output logic              qc_flag
);
  logic [WORD_W-1:0] calc_a, calc_b, calc_y;
  logic [SZ_W-1:0]   calc_size;
  logic              calc_uns, calc_sat;

  psub_word #(
    .WORD_W(WORD_W), .MIN_LANE(MIN_LANE), .NUM_SIZES(NUM_SIZES)
  ) u_word (
    .a(calc_a), .b(calc_b), .size(calc_size), .uns(calc_uns),
    .y(calc_y), .sat(calc_sat)
  );

  psub_seq #(
    .WORD_W(WORD_W), .IDX_W(IDX_W), .SZ_W(SZ_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_size(req_size), .req_uns(req_uns), .req_quad(req_quad),
    .req_dst(req_dst), .req_src1(req_src1), .req_src2(req_src2),
    .req_opa_lo(req_opa_lo), .req_opb_lo(req_opb_lo),
    .req_opa_hi(req_opa_hi), .req_opb_hi(req_opb_hi),
    .res_ready(res_ready), .qc_clear(qc_clear),
    .calc_a(calc_a), .calc_b(calc_b), .calc_size(calc_size), .calc_uns(calc_uns),
    .calc_y(calc_y), .calc_sat(calc_sat),
    .res_valid(res_valid), .res_data(res_data), .res_dst(res_dst),
    .res_sat(res_sat), .res_last(res_last), .res_undef(res_undef),
    .qc_flag(qc_flag)
  );
endmodule

// File: rtl/psub_sat_checker.sv
module psub_sat_checker #(
  parameter int WORD_W = 64,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic [WORD_W-1:0] res_data,
  input logic [IDX_W-1:0]  res_dst,
  input logic              res_sat,
  input logic              res_last,
  input logic              res_undef,
  input logic              qc_clear,
  input logic              qc_flag
);
  a_r12_no_take_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !req_ready);

  a_r11_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> res_valid);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_dst)
      && $stable(res_sat) && $stable(res_last) && $stable(res_undef)));

  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    qc_clear |=> !qc_flag);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (qc_flag && !qc_clear) |=> qc_flag);

  a_r6_set_on_sat: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(res_valid) && res_sat && !$past(qc_clear)) |-> qc_flag);

  a_r10_refused_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_undef) |-> (res_data == '0 && !res_sat && res_last));

  a_r9_second_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && !res_last) |=>
      (res_valid && res_last && !res_undef && res_dst == ($past(res_dst) + 1'b1)));
endmodule

bind psub_sat_unit psub_sat_checker #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
  .res_dst(res_dst), .res_sat(res_sat), .res_last(res_last),
  .res_undef(res_undef), .qc_clear(qc_clear), .qc_flag(qc_flag)
);

// File: tb/test_psub_sat_unit.sv
`timescale 1ns/1ps
module test_psub_sat_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_uns = 1'b0, req_quad = 1'b0;
  logic        req_ready;
  logic [1:0]  req_size = '0;
  logic [4:0]  req_dst = '0, req_src1 = '0, req_src2 = '0;
  logic [63:0] req_opa_lo = '0, req_opb_lo = '0, req_opa_hi = '0, req_opb_hi = '0;
  logic        res_valid, res_sat, res_last, res_undef, qc_flag;
  logic        res_ready = 1'b1, qc_clear = 1'b0;
  logic [63:0] res_data;
  logic [4:0]  res_dst;

  int checks = 0;
  int fails  = 0;
  bit qc_exp = 1'b0;
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  always #2.5 clk = ~clk;

  psub_sat_unit i_psub_sat_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_size(req_size), .req_uns(req_uns), .req_quad(req_quad),
    .req_dst(req_dst), .req_src1(req_src1), .req_src2(req_src2),
    .req_opa_lo(req_opa_lo), .req_opb_lo(req_opb_lo),
    .req_opa_hi(req_opa_hi), .req_opb_hi(req_opb_hi),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .res_dst(res_dst), .res_sat(res_sat), .res_last(res_last),
    .res_undef(res_undef), .qc_clear(qc_clear), .qc_flag(qc_flag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] lane_mask(input int w);
    return (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
  endfunction

  // Arithmetic model: exact difference in a wide signed integer, then clamp.
  function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                input logic [1:0] sz, input logic uns,
                                output logic [63:0] y, output logic sat);
    int w = 8 << sz;
    logic [63:0] m = lane_mask(w);
    y = '0;
    sat = 1'b0;
    for (int l = 0; l < 64 / w; l++) begin
      logic [63:0] la, lb;
      logic signed [67:0] ea, eb, d, lo, hi;
      la = (a >> (l * w)) & m;
      lb = (b >> (l * w)) & m;
      ea = $signed({4'b0, la});
      eb = $signed({4'b0, lb});
      if (!uns && la[w-1]) ea = ea - (68'sd1 <<< w);
      if (!uns && lb[w-1]) eb = eb - (68'sd1 <<< w);
      if (uns) begin
        lo = 68'sd0;
        hi = (68'sd1 <<< w) - 68'sd1;
      end else begin
        lo = -(68'sd1 <<< (w - 1));
        hi = (68'sd1 <<< (w - 1)) - 68'sd1;
      end
      d = ea - eb;
      if (d < lo) begin d = lo; sat = 1'b1; end
      if (d > hi) begin d = hi; sat = 1'b1; end
      y = y | ((d[63:0] & m) << (l * w));
    end
  endfunction

  function automatic logic [63:0] edge_val(input logic [1:0] sz, input int k);
    logic [63:0] m = lane_mask(8 << sz);
    logic [63:0] smax = m >> 1;
    case (k % 8)
      0: return 64'd0;
      1: return 64'd1;
      2: return smax;
      3: return smax + 64'd1;
      4: return smax + 64'd2;
      5: return m;
      6: return m - 64'd1;
      default: return 64'h5A3C_96E1_0F7B_C248 & m;
    endcase
  endfunction

  function automatic logic [63:0] pack_word(input logic [1:0] sz, input int base, input int step);
    int w = 8 << sz;
    logic [63:0] r = '0;
    for (int l = 0; l < 64 / w; l++) r = r | (edge_val(sz, base + step * l) << (l * w));
    return r;
  endfunction

  task automatic check_beat(input logic [63:0] a, input logic [63:0] b, input logic [1:0] sz,
                            input logic uns, input logic [4:0] dst, input bit last);
    logic [63:0] ey;
    logic es;
    model(a, b, sz, uns, ey, es);
    qc_exp = qc_exp | es;
    chk(res_valid == 1'b1, "R11", "res_valid", 64'(res_valid), 64'd1);
    chk(res_undef == 1'b0, "R10", "res_undef", 64'(res_undef), 64'd0);
    // R2 lane split with R3 (unsigned) or R4 (signed) clamping
    chk(res_data == ey, uns ? "R2 R3" : "R2 R4", "res_data", res_data, ey);
    chk(res_sat == es, "R5", "res_sat", 64'(res_sat), 64'(es));
    chk(res_dst == dst, last ? "R8 R9" : "R9", "res_dst", 64'(res_dst), 64'(dst));
    chk(res_last == last, "R9", "res_last", 64'(res_last), 64'(last));
    chk(qc_flag == qc_exp, "R6", "qc_flag", 64'(qc_flag), 64'(qc_exp));
  endtask

  task automatic do_op(input logic [1:0] sz, input logic uns, input logic quad,
                       input logic [4:0] d, input logic [4:0] s1, input logic [4:0] s2,
                       input logic [63:0] alo, input logic [63:0] blo,
                       input logic [63:0] ahi, input logic [63:0] bhi);
    bit refuse = quad && (d[0] || s1[0] || s2[0]);
    @(negedge clk);
    chk(req_ready == 1'b1, "R12", "req_ready idle", 64'(req_ready), 64'd1);
    req_size = sz; req_uns = uns; req_quad = quad;
    req_dst = d; req_src1 = s1; req_src2 = s2;
    req_opa_lo = alo; req_opb_lo = blo; req_opa_hi = ahi; req_opb_hi = bhi;
    req_valid = 1'b1; res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (refuse) begin
      chk(res_valid == 1'b1, "R10", "res_valid", 64'(res_valid), 64'd1);
      chk(res_undef == 1'b1, "R10", "res_undef", 64'(res_undef), 64'd1);
      chk(res_data == 64'd0, "R10", "res_data", res_data, 64'd0);
      chk(res_sat == 1'b0, "R10", "res_sat", 64'(res_sat), 64'd0);
      chk(res_last == 1'b1, "R10", "res_last", 64'(res_last), 64'd1);
      chk(qc_flag == qc_exp, "R10", "qc_flag", 64'(qc_flag), 64'(qc_exp));
    end else begin
      check_beat(alo, blo, sz, uns, d, !quad);
      if (quad) begin
        @(negedge clk);
        check_beat(ahi, bhi, sz, uns, d + 5'd1, 1'b1);
      end
    end
    @(negedge clk);
    chk(res_valid == 1'b0, "R8 R9", "no extra word", 64'(res_valid), 64'd0);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_valid == 1'b0, "R1", "res_valid", 64'(res_valid), 64'd0);
    chk(req_ready == 1'b1, "R1", "req_ready", 64'(req_ready), 64'd1);
    chk(qc_flag == 1'b0, "R1", "qc_flag", 64'(qc_flag), 64'd0);

    // Edge-value sweep over every size and type, single and quad
    for (int sz = 0; sz < 4; sz++)
      for (int u = 0; u < 2; u++)
        for (int ia = 0; ia < 8; ia++)
          for (int ib = 0; ib < 8; ib++)
            do_op(2'(sz), 1'(u), 1'((ia + ib) & 1), 5'(2 * ((ia + ib) % 16)), 5'(2 * ia), 5'(2 * ib),
                  pack_word(2'(sz), ia, 1), pack_word(2'(sz), ib, 3),
                  pack_word(2'(sz), ib, 5), pack_word(2'(sz), ia, 2));

    // Pseudo-random operands
    for (int n = 0; n < 400; n++) begin
      logic [63:0] r0, r1, r2, r3;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17); r0 = lfsr;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17); r1 = lfsr;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17); r2 = lfsr;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17); r3 = lfsr;
      do_op(r0[1:0], r0[2], r0[3], {r0[7:4], 1'b0}, {r0[11:8], 1'b0}, {r0[15:12], 1'b0},
            r0, r1, r2, r3);
    end

    // R7: clear on its own
    if (!qc_exp) do_op(2'd0, 1'b1, 1'b0, 5'd2, 5'd4, 5'd6, 64'd0, 64'd1, 64'd0, 64'd0);
    @(negedge clk); qc_clear = 1'b1;
    @(negedge clk); qc_clear = 1'b0; qc_exp = 1'b0;
    chk(qc_flag == 1'b0, "R7", "qc after clear", 64'(qc_flag), 64'd0);

    // R7: clear on the same edge as a clamping word is loaded
    @(negedge clk);
    req_size = 2'd0; req_uns = 1'b1; req_quad = 1'b0;
    req_dst = 5'd8; req_src1 = 5'd2; req_src2 = 5'd4;
    req_opa_lo = 64'd0; req_opb_lo = 64'd1; req_valid = 1'b1; qc_clear = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; qc_clear = 1'b0;
    chk(res_sat == 1'b1, "R7", "res_sat same edge", 64'(res_sat), 64'd1);
    chk(qc_flag == 1'b0, "R7", "qc clear over set", 64'(qc_flag), 64'd0);
    @(negedge clk);

    // R10: odd index in each position, with clamping operands; flag must stay 0
    do_op(2'd0, 1'b1, 1'b1, 5'd3, 5'd2, 5'd4, 64'd0, {64{1'b1}}, 64'd0, {64{1'b1}});
    do_op(2'd1, 1'b0, 1'b1, 5'd2, 5'd5, 5'd4, 64'd0, {64{1'b1}}, 64'd0, {64{1'b1}});
    do_op(2'd3, 1'b1, 1'b1, 5'd2, 5'd4, 5'd31, 64'd0, {64{1'b1}}, 64'd0, {64{1'b1}});
    chk(qc_flag == 1'b0, "R10", "qc after refusals", 64'(qc_flag), 64'd0);
    // R8: odd indices are fine when not quad
    do_op(2'd2, 1'b0, 1'b0, 5'd7, 5'd9, 5'd11, 64'h8000_0000_7FFF_FFFF, 64'h0000_0001_FFFF_FFFF, 64'd0, 64'd0);

    // R11/R12: stall the consumer while a competing request is offered
    @(negedge clk);
    req_size = 2'd1; req_uns = 1'b0; req_quad = 1'b1;
    req_dst = 5'd12; req_src1 = 5'd14; req_src2 = 5'd16;
    req_opa_lo = 64'h8000_7FFF_0001_1234; req_opb_lo = 64'h0001_FFFF_0002_0034;
    req_opa_hi = 64'h0000_0010_FFFF_7FFE; req_opb_hi = 64'h0001_0020_0001_FFFE;
    req_valid = 1'b1; res_ready = 1'b0;
    @(negedge clk);
    begin
      logic [63:0] e0, e1;
      logic s0, s1x;
      model(64'h8000_7FFF_0001_1234, 64'h0001_FFFF_0002_0034, 2'd1, 1'b0, e0, s0);
      model(64'h0000_0010_FFFF_7FFE, 64'h0001_0020_0001_FFFE, 2'd1, 1'b0, e1, s1x);
      req_opa_lo = 64'h1111; req_opb_lo = 64'h2222; req_dst = 5'd20; req_quad = 1'b0;
      for (int k = 0; k < 3; k++) begin
        chk(req_ready == 1'b0, "R12", "req_ready busy", 64'(req_ready), 64'd0);
        chk(res_data == e0, "R11", "held beat0", res_data, e0);
        chk(res_dst == 5'd12, "R11", "held dst", 64'(res_dst), 64'd12);
        @(negedge clk);
      end
      req_valid = 1'b0; res_ready = 1'b1;
      @(negedge clk);
      chk(res_data == e1, "R9", "beat1 data", res_data, e1);
      chk(res_dst == 5'd13, "R9", "beat1 dst", 64'(res_dst), 64'd13);
      chk(res_sat == s1x, "R5", "beat1 sat", 64'(res_sat), 64'(s1x));
      @(negedge clk);
      chk(res_valid == 1'b0, "R12", "offered request not taken", 64'(res_valid), 64'd0);
      chk(qc_flag == (s0 | s1x), "R6", "qc after stall op", 64'(qc_flag), 64'(s0 | s1x));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule